// File: doc/BRIEF.md
# Copy Engine Interrupt Status Aggregator

This block gathers interrupt events from a parameterised set of copy engines and turns them into per-engine status, a one-bit-per-engine pending summary and one shared interrupt line. Every engine owns six sticky status bits: copy-complete, error, and four watermark bits (source high, source low, destination high, destination low). Copy-complete and error arrive as one-cycle event pulses. The block derives the watermark events itself, by comparing the occupancy of each engine's source and destination rings against high and low thresholds that software programs.

Software reaches the block through a simple write port. It selects an engine and a register, then writes. Separate enables decide which status bits count towards that engine's summary bit. Status bits are cleared by writing ones. Status bits set even while their enables are off. The shared interrupt is the OR of the summary vector, registered once.

Top module: `ce_irq_collector`

## Requirements
- R1: After reset all status bits, enables, summary bits and the interrupt output are 0, every low threshold is 0 and every high threshold equals RING_DEPTH.
- R2: A copy-complete pulse on an engine sets its status bit 0 on the next clock edge, and the bit stays set until it is cleared.
- R3: An error pulse on an engine sets its status bit 5 on the next clock edge, and the bit stays set until it is cleared.
- R4: A write with register select 2 clears each status bit of the addressed engine whose data bit is 1 (bit i clears status bit i). Status bits whose data bit is 0 keep their value.
- R5: If an event for a status bit arrives in the same cycle as a clear of that bit, the bit stays set.
- R6: A high-watermark status bit sets when that ring's occupancy goes from below the high threshold to at or above it. Bit 1 is for the source ring and bit 3 for the destination ring. Occupancy that stays at or above the threshold does not set the bit again.
- R7: A low-watermark status bit sets when that ring's occupancy goes from above the low threshold to at or below it. Bit 2 is for the source ring and bit 4 for the destination ring. Occupancy that stays at or below the threshold does not set the bit again.
- R8: Status bits set whatever the value of the enables.
- R9: Summary bit e is 1 exactly when engine e has a status bit i (for i from 0 to 4) set with host-enable bit i set, or has status bit 5 set with error-enable bit 0 set.
- R10: The interrupt output equals the OR of the summary vector one clock cycle earlier.
- R11: A threshold register holds the low threshold in data bits [OCC_W-1:0] and the high threshold in bits [2*OCC_W-1:OCC_W]. A write affects only the addressed engine.
- R12: Register select codes are 0 for host enable, 1 for error enable, 2 for status clear, 3 for source thresholds and 4 for destination thresholds. A write with select codes 5 to 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cc_evt_i | input | NUM_ENG | Copy-complete event pulse, one bit per engine |
| err_evt_i | input | NUM_ENG | Error event pulse, one bit per engine |
| src_occ_i | input | NUM_ENG*OCC_W | Source ring occupancy, engine e in slice e |
| dst_occ_i | input | NUM_ENG*OCC_W | Destination ring occupancy, engine e in slice e |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_eng_i | input | ENG_W | Engine addressed by the write |
| cfg_sel_i | input | 3 | Register select code |
| cfg_wdata_i | input | CFG_W | Write data |
| stat_o | output | NUM_ENG*6 | Status bits, engine e in bits [6e+5:6e] |
| summary_o | output | NUM_ENG | Per-engine pending summary |
| irq_o | output | 1 | Shared interrupt, registered |

## Verification
Assertions check on every cycle that an event always leaves its status bit set (R5 included), that a clear without a competing event always empties the bits it names, and that status holds when neither happens. They also check that a watermark detector never fires twice in a row and that the interrupt line trails the summary by exactly one cycle. Only the bench scenarios show the remaining properties: the default threshold values, the field positions within the threshold register, that ignored select codes change nothing, isolation between engines, and that the enables gate the summary without gating the status.

// File: rtl/ce_irq_pkg.sv
package ce_irq_pkg;
  localparam int ST_W      = 6;
  localparam int HOST_EN_W = 5;
  localparam int ST_CC     = 0;
  localparam int ST_SRC_HI = 1;
  localparam int ST_SRC_LO = 2;
  localparam int ST_DST_HI = 3;
  localparam int ST_DST_LO = 4;
  localparam int ST_ERR    = 5;

  typedef enum logic [2:0] {
    SEL_HOST_EN  = 3'd0,
    SEL_ERR_EN   = 3'd1,
    SEL_STAT_CLR = 3'd2,
    SEL_SRC_WM   = 3'd3,
    SEL_DST_WM   = 3'd4
  } cfg_sel_e;
endpackage

// File: rtl/wm_detect.sv
module wm_detect #(
  parameter int OCC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OCC_W-1:0] occ_i,
  input  logic [OCC_W-1:0] lo_i,
  input  logic [OCC_W-1:0] hi_i,
  output logic             hi_evt_o,
  output logic             lo_evt_o
);
  logic above_now, below_now;
  logic above_q, below_q;

  assign above_now = (occ_i >= hi_i);
  assign below_now = (occ_i <= lo_i);

  // After reset the ring is taken as empty: below low, not above high.
  always_ff @(posedge clk) begin
    if (rst) begin
      above_q <= 1'b0;
      below_q <= 1'b1;
    end else begin
      above_q <= above_now;
      below_q <= below_now;
    end
  end

  assign hi_evt_o = above_now & ~above_q;
  assign lo_evt_o = below_now & ~below_q;

  // R6
  no_double_hi_chk: assert property (@(posedge clk) disable iff (rst)
    hi_evt_o |=> !hi_evt_o);
  // R7
  no_double_lo_chk: assert property (@(posedge clk) disable iff (rst)
    lo_evt_o |=> !lo_evt_o);
endmodule

// File: rtl/eng_irq_slice.sv
module eng_irq_slice
  import ce_irq_pkg::*;
#(
  parameter int OCC_W      = 6,
  parameter int RING_DEPTH = 32,
  parameter int CFG_W      = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cc_evt_i,
  input  logic             err_evt_i,
  input  logic [OCC_W-1:0] src_occ_i,
  input  logic [OCC_W-1:0] dst_occ_i,
  input  logic             wr_i,
  input  logic [2:0]       sel_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [ST_W-1:0]  stat_o,
  output logic             pend_o
);
  localparam logic [OCC_W-1:0] HI_RST = OCC_W'(RING_DEPTH);

  logic [HOST_EN_W-1:0] host_en_q;
  logic                 err_en_q;
  logic [OCC_W-1:0]     src_lo_q, src_hi_q, dst_lo_q, dst_hi_q;
  logic [ST_W-1:0]      stat_q;
  logic [ST_W-1:0]      clr_mask, evt_vec;
  logic                 src_hi_evt, src_lo_evt, dst_hi_evt, dst_lo_evt;

  wm_detect #(.OCC_W(OCC_W)) u_src_wm (
    .clk(clk), .rst(rst), .occ_i(src_occ_i), .lo_i(src_lo_q), .hi_i(src_hi_q),
    .hi_evt_o(src_hi_evt), .lo_evt_o(src_lo_evt)
  );

  wm_detect #(.OCC_W(OCC_W)) u_dst_wm (
    .clk(clk), .rst(rst), .occ_i(dst_occ_i), .lo_i(dst_lo_q), .hi_i(dst_hi_q),
    .hi_evt_o(dst_hi_evt), .lo_evt_o(dst_lo_evt)
  );

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      host_en_q <= '0;
      err_en_q  <= 1'b0;
      src_lo_q  <= '0;
      src_hi_q  <= HI_RST;
      dst_lo_q  <= '0;
      dst_hi_q  <= HI_RST;
    end else if (wr_i) begin
      case (sel_i)
        SEL_HOST_EN: host_en_q <= wdata_i[HOST_EN_W-1:0];
        SEL_ERR_EN:  err_en_q  <= wdata_i[0];
        SEL_SRC_WM: begin
          src_lo_q <= wdata_i[OCC_W-1:0];
          src_hi_q <= wdata_i[2*OCC_W-1:OCC_W];
        end
        SEL_DST_WM: begin
          dst_lo_q <= wdata_i[OCC_W-1:0];
          dst_hi_q <= wdata_i[2*OCC_W-1:OCC_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    clr_mask = '0;
    if (wr_i && (sel_i == SEL_STAT_CLR)) clr_mask = wdata_i[ST_W-1:0];
  end

  always_comb begin
    evt_vec            = '0;
    evt_vec[ST_CC]     = cc_evt_i;
    evt_vec[ST_SRC_HI] = src_hi_evt;
    evt_vec[ST_SRC_LO] = src_lo_evt;
    evt_vec[ST_DST_HI] = dst_hi_evt;
    evt_vec[ST_DST_LO] = dst_lo_evt;
    evt_vec[ST_ERR]    = err_evt_i;
  end

  // Sticky status: a new event outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_mask) | evt_vec;
  end

  assign stat_o = stat_q;
  assign pend_o = (|(stat_q[HOST_EN_W-1:0] & host_en_q)) | (stat_q[ST_ERR] & err_en_q);

  // R2 R3 R5 R6 R7
  evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_vec) |=> ((stat_q & $past(evt_vec)) == $past(evt_vec)));
  // R4
  clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (|clr_mask) |=> ((stat_q & $past(clr_mask) & ~$past(evt_vec)) == '0));
  // R4
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((clr_mask == '0) && (evt_vec == '0)) |=> $stable(stat_q));
  // R9
  idle_no_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q == '0) |-> !pend_o);
endmodule

// File: rtl/ce_irq_collector.sv
module ce_irq_collector
  import ce_irq_pkg::*;
#(
  parameter  int NUM_ENG    = 4,
  parameter  int RING_DEPTH = 32,
  localparam int OCC_W      = $clog2(RING_DEPTH + 1),
  localparam int CFG_W      = (2 * OCC_W > ST_W) ? 2 * OCC_W : ST_W,
  localparam int ENG_W      = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_ENG-1:0]       cc_evt_i,
  input  logic [NUM_ENG-1:0]       err_evt_i,
  input  logic [NUM_ENG*OCC_W-1:0] src_occ_i,
  input  logic [NUM_ENG*OCC_W-1:0] dst_occ_i,
  input  logic                     cfg_we_i,
  input  logic [ENG_W-1:0]         cfg_eng_i,
  input  logic [2:0]               cfg_sel_i,
  input  logic [CFG_W-1:0]         cfg_wdata_i,
  output logic [NUM_ENG*ST_W-1:0]  stat_o,
  output logic [NUM_ENG-1:0]       summary_o,
  output logic                     irq_o
);
  logic [NUM_ENG-1:0] pend;
  logic               irq_q;

  if (NUM_ENG < 1 || NUM_ENG > 16) begin : g_bad_count
    $error("NUM_ENG must lie between 1 and 16");
  end

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
    logic sel_me;
    assign sel_me = cfg_we_i && (cfg_eng_i == ENG_W'(g));

    eng_irq_slice #(
      .OCC_W(OCC_W), .RING_DEPTH(RING_DEPTH), .CFG_W(CFG_W)
    ) u_slice (
      .clk(clk),
      .rst(rst),
      .cc_evt_i(cc_evt_i[g]),
      .err_evt_i(err_evt_i[g]),
      .src_occ_i(src_occ_i[g*OCC_W +: OCC_W]),
      .dst_occ_i(dst_occ_i[g*OCC_W +: OCC_W]),
      .wr_i(sel_me),
      .sel_i(cfg_sel_i),
      .wdata_i(cfg_wdata_i),
      .stat_o(stat_o[g*ST_W +: ST_W]),
      .pend_o(pend[g])
    );
  end

  assign summary_o = pend;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend;
  end

  assign irq_o = irq_q;

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (|summary_o) |=> irq_o);
  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (summary_o == '0) |=> !irq_o);
endmodule

// File: tb/tb_ce_irq_collector.sv
module tb_ce_irq_collector;
  localparam int N  = 4;
  localparam int D  = 32;
  localparam int OW = 6;
  localparam int CW = 12;

  logic            clk = 1'b0;
  logic            rst;
  logic [N-1:0]    cc_evt, err_evt;
  logic [N*OW-1:0] src_occ, dst_occ;
  logic            cfg_we;
  logic [1:0]      cfg_eng;
  logic [2:0]      cfg_sel;
  logic [CW-1:0]   cfg_wdata;
  logic [N*6-1:0]  stat;
  logic [N-1:0]    summary;
  logic            irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ce_irq_collector #(.NUM_ENG(N), .RING_DEPTH(D)) dut (
    .clk(clk), .rst(rst), .cc_evt_i(cc_evt), .err_evt_i(err_evt),
    .src_occ_i(src_occ), .dst_occ_i(dst_occ), .cfg_we_i(cfg_we),
    .cfg_eng_i(cfg_eng), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .stat_o(stat), .summary_o(summary), .irq_o(irq)
  );

  typedef struct packed {
    logic [3:0]  cc;
    logic [3:0]  err;
    logic        we;
    logic [1:0]  eng;
    logic [2:0]  sel;
    logic [11:0] data;
    logic [1:0]  ceng;
    logic [5:0]  st;
    logic [3:0]  sm;
  } row_t;

  // Each row: stimulus for one cycle, then status of one engine and the summary.
  localparam row_t TBL [0:10] = '{
    '{4'b0001, 4'b0000, 1'b0, 2'd0, 3'd0, 12'h000, 2'd0, 6'b000001, 4'b0000}, // R2 R8
    '{4'b0000, 4'b0000, 1'b1, 2'd0, 3'd0, 12'h001, 2'd0, 6'b000001, 4'b0001}, // R9
    '{4'b0000, 4'b0010, 1'b0, 2'd0, 3'd0, 12'h000, 2'd1, 6'b100000, 4'b0001}, // R3
    '{4'b0000, 4'b0000, 1'b1, 2'd1, 3'd1, 12'h001, 2'd1, 6'b100000, 4'b0011}, // R9 R12
    '{4'b0000, 4'b0000, 1'b1, 2'd0, 3'd2, 12'h001, 2'd0, 6'b000000, 4'b0010}, // R4
    '{4'b0000, 4'b0000, 1'b1, 2'd1, 3'd2, 12'h001, 2'd1, 6'b100000, 4'b0010}, // R4
    '{4'b1000, 4'b0000, 1'b1, 2'd3, 3'd0, 12'h001, 2'd3, 6'b000001, 4'b1010}, // R2 R9
    '{4'b1000, 4'b0000, 1'b1, 2'd3, 3'd2, 12'h001, 2'd3, 6'b000001, 4'b1010}, // R5
    '{4'b0000, 4'b0000, 1'b1, 2'd3, 3'd5, 12'h03F, 2'd3, 6'b000001, 4'b1010}, // R12
    '{4'b0000, 4'b0000, 1'b1, 2'd1, 3'd2, 12'h020, 2'd1, 6'b000000, 4'b1000}, // R4
    '{4'b0000, 4'b0000, 1'b1, 2'd3, 3'd2, 12'h001, 2'd3, 6'b000000, 4'b0000}  // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int e, input int s, input logic [CW-1:0] d);
    cfg_we    = 1'b1;
    cfg_eng   = 2'(e);
    cfg_sel   = 3'(s);
    cfg_wdata = d;
    tick();
    cfg_we    = 1'b0;
  endtask

  function automatic logic [5:0] st_of(input int e);
    return stat[e*6 +: 6];
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cc_evt = '0; err_evt = '0; src_occ = '0; dst_occ = '0;
    cfg_we = 1'b0; cfg_eng = '0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 status", 32'(stat), 32'd0);
    check("R1 summary", 32'(summary), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);

    for (int i = 0; i < 11; i++) begin
      cc_evt = TBL[i].cc; err_evt = TBL[i].err; cfg_we = TBL[i].we;
      cfg_eng = TBL[i].eng; cfg_sel = TBL[i].sel; cfg_wdata = TBL[i].data;
      tick();
      cc_evt = '0; err_evt = '0; cfg_we = 1'b0;
      check($sformatf("R2-R5/R9/R12 row %0d status", i), 32'(st_of(int'(TBL[i].ceng))), 32'(TBL[i].st));
      check($sformatf("R9 row %0d summary", i), 32'(summary), 32'(TBL[i].sm));
      tick();
      check($sformatf("R10 row %0d irq", i), 32'(irq), 32'(|TBL[i].sm));
    end

    // R1 R6: default high threshold equals ring depth
    src_occ[2*OW +: OW] = 6'd32; tick();
    check("R6 default high", 32'(st_of(2)), 32'b000010);
    src_occ[2*OW +: OW] = 6'd31; tick();
    check("R6 no extra event", 32'(st_of(2)), 32'b000010);
    // R1 R7: default low threshold is zero
    src_occ[2*OW +: OW] = 6'd0; tick();
    check("R7 default low", 32'(st_of(2)), 32'b000110);
    wr(2, 2, 12'h006);
    check("R4 clear watermark", 32'(st_of(2)), 32'd0);
    tick();
    check("R7 level does not retrigger", 32'(st_of(2)), 32'd0);

    // R11: destination thresholds low=4 high=10
    wr(2, 4, 12'((10 << 6) | 4));
    dst_occ[2*OW +: OW] = 6'd9; tick();
    check("R11 below high", 32'(st_of(2)), 32'd0);
    dst_occ[2*OW +: OW] = 6'd10; tick();
    check("R6 R11 dst high", 32'(st_of(2)), 32'b001000);
    dst_occ[2*OW +: OW] = 6'd12; tick();
    wr(2, 2, 12'h008);
    dst_occ[2*OW +: OW] = 6'd5; tick();
    check("R7 above low", 32'(st_of(2)), 32'd0);
    dst_occ[2*OW +: OW] = 6'd4; tick();
    check("R7 dst low", 32'(st_of(2)), 32'b010000);
    check("R11 other engine", 32'(st_of(3)), 32'd0);
    check("R8 status without enable", 32'(summary), 32'd0);

    // R9 R10: enable watermarks on engine 2
    wr(2, 0, 12'h01E);
    check("R9 wm enable", 32'(summary), 32'b0100);
    check("R10 latency rise", 32'(irq), 32'd0);
    tick();
    check("R10 irq set", 32'(irq), 32'd1);
    wr(2, 2, 12'h010);
    check("R9 cleared", 32'(summary), 32'd0);
    check("R10 latency fall", 32'(irq), 32'd1);
    tick();
    check("R10 irq clear", 32'(irq), 32'd0);

    // R11: source field positions, high=3 low=1
    wr(1, 3, 12'((3 << 6) | 1));
    src_occ[1*OW +: OW] = 6'd3; tick();
    check("R11 src high field", 32'(st_of(1)), 32'b000010);
    // R5: low event and clear of bits 1,2 in one cycle
    src_occ[1*OW +: OW] = 6'd1;
    wr(1, 2, 12'h006);
    check("R5 event beats clear", 32'(st_of(1)), 32'b000100);

    // R1: reset mid-run clears enables as well as status
    rst = 1'b1; tick(); rst = 1'b0;
    src_occ = '0; dst_occ = '0; tick();
    check("R1 status after reset", 32'(stat), 32'd0);
    cc_evt = 4'b0001; tick(); cc_evt = '0;
    check("R1 enable cleared", 32'(summary), 32'd0);
    check("R2 after reset", 32'(st_of(0)), 32'b000001);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule